// File: doc/BRIEF.md
# Two-Input Arrival-Order Detector

This block watches two level inputs, `in_a` and `in_b`, which rest together at zero between uses. When both have gone high it reports which of the two got there first. Two order flags give the answer. `first_b` means `in_b` rose before `in_a`, and `first_a` means `in_a` rose before `in_b`. A separate `lead` flag is high from the moment the first input rises until the second one joins it. Once an order flag is set it holds until both inputs are back at zero. The outputs therefore depend on the order in which the inputs arrived, not on their present levels.

The behaviour follows a fundamental-mode flow table, sampled on a clock. Both inputs pass through a synchroniser before a small state register acts on them. The table assumes that only one input changes at a time. When both synchronised inputs change in the same sample, the block gives no order answer. It raises `err` for one cycle and then ignores the inputs until they return to zero together.

Top module: `arrival_order_detector`

## Requirements
- R1: When `rst` is high at a rising edge, all four outputs are 0 after that edge and the block is back in its idle state.
- R2: While the synchronised inputs rest at 00 and no pulse is due, the outputs `first_a`, `first_b`, `lead` and `err` are all 0.
- R3: A change on the raw inputs reaches the outputs after the third rising edge that follows it: two synchroniser stages and then the state register. After the second edge the outputs still show the old value.
- R4: When `in_b` rises first and `in_a` then rises, `first_b` becomes 1 and `first_a` stays 0.
- R5: When `in_a` rises first and `in_b` then rises, `first_a` becomes 1 and `first_b` stays 0.
- R6: Once set, an order flag keeps its value through any input change until both synchronised inputs are 0. On that sample the flag clears.
- R7: `lead` goes to 1 when exactly one input rises from the idle state.
- R8: `lead` falls to 0 when the second input arrives. It stays 0 until the inputs return to 00, even if one input falls before then.
- R9: If a single input rises and falls back to 00 before the other rises, all outputs return to 0 and no order flag is produced. The next arrival is then judged afresh.
- R10: A two-input change within one synchronised sample is a fault. This covers 00 to 11, and 10 to 01 or 01 to 10 while one input leads. On a fault `err` is 1 for exactly one cycle and no order flag is set. The outputs then stay 0 until the inputs return to 00.
- R11: At most one of `first_a`, `first_b` and `lead` is 1 at any time, and no order flag is 1 while `err` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| in_a | input | 1 | First watched level input, asynchronous |
| in_b | input | 1 | Second watched level input, asynchronous |
| first_a | output | 1 | `in_a` arrived before `in_b` |
| first_b | output | 1 | `in_b` arrived before `in_a` |
| lead | output | 1 | Exactly one input has arrived so far |
| err | output | 1 | One-cycle pulse on a two-input change |

## Verification
A wrong internal state shows up within three edges of the input change that should have produced it. It appears as a wrong order flag, a missing `lead`, or an `err` pulse at the wrong time. The deeper danger is a state that fails to notice a return to 00. Such a state would hold a stale order flag, or keep ignoring inputs, well into the next sequence. The stimulus therefore follows every sequence with a fresh arrival, so that a stuck state is exposed on the next use rather than hidden.

// File: rtl/arrord_pkg.sv
package arrord_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_A_LEAD = 3'd1,
    ST_B_LEAD = 3'd2,
    ST_A_WON  = 3'd3,
    ST_B_WON  = 3'd4,
    ST_FAULT  = 3'd5
  } ord_state_t;

  typedef struct packed {
    logic first_a;
    logic first_b;
    logic lead;
  } ord_flags_t;

  // Flow-table step on one synchronised sample of the two inputs
  function automatic ord_state_t ord_next(ord_state_t cur, logic a, logic b);
    ord_state_t nxt;
    nxt = cur;
    case (cur)
      ST_IDLE: begin
        if (a && b)      nxt = ST_FAULT;
        else if (a)      nxt = ST_A_LEAD;
        else if (b)      nxt = ST_B_LEAD;
      end
      ST_A_LEAD: begin
        case ({a, b})
          2'b00:   nxt = ST_IDLE;
          2'b11:   nxt = ST_A_WON;
          2'b01:   nxt = ST_FAULT;
          default: nxt = ST_A_LEAD;
        endcase
      end
      ST_B_LEAD: begin
        case ({a, b})
          2'b00:   nxt = ST_IDLE;
          2'b11:   nxt = ST_B_WON;
          2'b10:   nxt = ST_FAULT;
          default: nxt = ST_B_LEAD;
        endcase
      end
      ST_A_WON, ST_B_WON, ST_FAULT: begin
        if (!a && !b)    nxt = ST_IDLE;
      end
      default:           nxt = ST_IDLE;
    endcase
    return nxt;
  endfunction

  function automatic logic ord_fault_entry(ord_state_t cur, ord_state_t nxt);
    return (nxt == ST_FAULT) && (cur != ST_FAULT);
  endfunction

  function automatic ord_flags_t ord_decode(ord_state_t st);
    ord_flags_t f;
    f.first_a = (st == ST_A_WON);
    f.first_b = (st == ST_B_WON);
    f.lead    = (st == ST_A_LEAD) || (st == ST_B_LEAD);
    return f;
  endfunction

endpackage

// File: rtl/arrord_sync.sv
module arrord_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_async;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q_sync = chain[LAST];
endmodule

// File: rtl/arrord_fsm.sv
module arrord_fsm
  import arrord_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       a_s,
  input  logic       b_s,
  output ord_state_t state,
  output logic       fault_pulse
);
  ord_state_t state_nxt;

  always_comb state_nxt = ord_next(state, a_s, b_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      fault_pulse <= 1'b0;
    end else begin
      state       <= state_nxt;
      fault_pulse <= ord_fault_entry(state, state_nxt);
    end
  end
endmodule

// File: rtl/arrord_decode.sv
module arrord_decode
  import arrord_pkg::*;
(
  input  ord_state_t state,
  output logic       first_a,
  output logic       first_b,
  output logic       lead
);
  ord_flags_t f;
  always_comb f = ord_decode(state);
  assign first_a = f.first_a;
  assign first_b = f.first_b;
  assign lead    = f.lead;
endmodule

// File: rtl/arrival_order_detector.sv
module arrival_order_detector
  import arrord_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic in_a,
  input  logic in_b,
  output logic first_a,
  output logic first_b,
  output logic lead,
  output logic err
);
  localparam int NUM_IN = 2;

  logic [NUM_IN-1:0] raw_pair;
  logic [NUM_IN-1:0] sync_pair;
  logic              sync_a;
  logic              sync_b;
  ord_state_t        cur_state;

  assign raw_pair = {in_a, in_b};
  assign sync_a   = sync_pair[1];
  assign sync_b   = sync_pair[0];

  arrord_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (raw_pair),
    .q_sync  (sync_pair)
  );

  arrord_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .a_s         (sync_a),
    .b_s         (sync_b),
    .state       (cur_state),
    .fault_pulse (err)
  );

  arrord_decode u_dec (
    .state   (cur_state),
    .first_a (first_a),
    .first_b (first_b),
    .lead    (lead)
  );
endmodule

// File: rtl/arrord_chk.sv
module arrord_chk (
  input logic clk,
  input logic rst,
  input logic sync_a,
  input logic sync_b,
  input logic first_a,
  input logic first_b,
  input logic lead,
  input logic err
);
  // R11
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({first_a, first_b, lead}));

  // R11
  err_no_order_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (!first_a && !first_b));

  // R10
  err_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  // R6
  hold_a_chk: assert property (@(posedge clk) disable iff (rst)
    (first_a && (sync_a || sync_b)) |=> first_a);

  // R6
  hold_b_chk: assert property (@(posedge clk) disable iff (rst)
    (first_b && (sync_a || sync_b)) |=> first_b);

  // R5
  a_win_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(first_a) |-> ($past(lead) && $past(sync_a && sync_b)));

  // R4
  b_win_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(first_b) |-> ($past(lead) && $past(sync_a && sync_b)));

  // R7
  lead_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lead) |-> $past(sync_a ^ sync_b));

  // R8
  lead_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lead) |-> ($past(sync_a == sync_b) || err));
endmodule

bind arrival_order_detector arrord_chk u_arrord_chk (
  .clk     (clk),
  .rst     (rst),
  .sync_a  (sync_a),
  .sync_b  (sync_b),
  .first_a (first_a),
  .first_b (first_b),
  .lead    (lead),
  .err     (err)
);

// File: tb/tb_arrival_order_detector.sv
`timescale 1ns/1ps
module tb_arrival_order_detector;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_a = 1'b0;
  logic in_b = 1'b0;
  logic first_a, first_b, lead, err;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;

  always #10 clk = ~clk;

  arrival_order_detector dut (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b),
    .first_a(first_a), .first_b(first_b), .lead(lead), .err(err)
  );

  // Reference: sample history queue plus a behavioural order tracker
  logic [1:0] hist[$];
  int  who_first;   // 0 none, 1 a, 2 b
  bit  decided;     // order answered or fault: ignore until 00
  bit  faulted;
  bit  m_err;

  function automatic logic [3:0] model_vec();
    logic fa, fb, ld;
    fa = decided && !faulted && who_first == 1;
    fb = decided && !faulted && who_first == 2;
    ld = !decided && who_first != 0;
    return {fb, fa, ld, m_err};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      hist = '{2'b00, 2'b00};
      who_first = 0; decided = 0; faulted = 0; m_err = 0;
    end else begin
      logic [1:0] smp;
      int ups;
      smp = hist.pop_front();
      m_err = 0;
      ups = int'(smp[1]) + int'(smp[0]);
      if (smp == 2'b00) begin
        who_first = 0; decided = 0; faulted = 0;
      end else if (!decided) begin
        if (who_first == 0) begin
          if (ups == 2) begin decided = 1; faulted = 1; m_err = 1; end
          else who_first = smp[1] ? 1 : 2;
        end else if (ups == 2) begin
          decided = 1;
        end else if ((who_first == 1 && !smp[1]) || (who_first == 2 && !smp[0])) begin
          decided = 1; faulted = 1; m_err = 1;
        end
      end
      hist.push_back({in_a, in_b});
    end
    started = 1;
  end

  // R3: cycle-accurate comparison against the reference every clock
  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if ({first_b, first_a, lead, err} !== model_vec()) begin
        errors++;
        $display("FAIL R3 per-cycle model: actual %b expected %b at %0t",
                 {first_b, first_a, lead, err}, model_vec(), $time);
      end
    end
  end

  task automatic chk(input string req, input logic [3:0] exp);
    checks++;
    if ({first_b, first_a, lead, err} !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (first_b,first_a,lead,err) at %0t",
               req, {first_b, first_a, lead, err}, exp, $time);
    end
  endtask

  task automatic drive(input logic a, input logic b, input int waitn);
    @(negedge clk);
    in_a = a; in_b = b;
    repeat (waitn) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", 4'b0000);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 idle", 4'b0000);

    // R3 latency, R7 lead
    drive(1, 0, 2);
    chk("R3 before third edge", 4'b0000);
    @(negedge clk);
    chk("R3 R7 lead after third edge", 4'b0010);
    // R5 a first, R8 lead clears
    drive(1, 1, 4);
    chk("R5 R8 a first", 4'b0100);
    drive(0, 1, 4);
    chk("R6 R8 hold after a falls", 4'b0100);
    drive(1, 1, 4);
    chk("R6 hold after a returns", 4'b0100);
    drive(1, 0, 4);
    chk("R6 hold after b falls", 4'b0100);
    drive(0, 0, 4);
    chk("R6 R2 clear at 00", 4'b0000);

    // R4 b first
    drive(0, 1, 4);
    chk("R7 lead on b", 4'b0010);
    drive(1, 1, 4);
    chk("R4 b first", 4'b1000);
    drive(1, 0, 4);
    chk("R6 R8 hold b order", 4'b1000);
    drive(0, 0, 4);
    chk("R6 clear b order", 4'b0000);

    // R9 abandoned arrival
    drive(1, 0, 4);
    drive(0, 0, 4);
    chk("R9 abandoned arrival", 4'b0000);
    drive(0, 1, 4);
    drive(1, 1, 4);
    chk("R9 fresh judgement", 4'b1000);
    drive(0, 0, 4);

    // R10 simultaneous rise
    drive(1, 1, 3);
    chk("R10 err pulse", 4'b0001);
    @(negedge clk);
    chk("R10 err one cycle", 4'b0000);
    drive(0, 1, 4);
    chk("R10 ignored while faulted", 4'b0000);
    drive(1, 1, 4);
    chk("R10 still ignored", 4'b0000);
    drive(0, 0, 4);
    drive(1, 0, 4);
    chk("R10 recovered", 4'b0010);

    // R10 swap while leading
    drive(0, 1, 3);
    chk("R10 swap err", 4'b0001);
    @(negedge clk);
    chk("R10 swap no lead", 4'b0000);
    drive(0, 0, 4);

    // R1 reset mid-sequence
    drive(1, 0, 4);
    drive(1, 1, 4);
    chk("R5 before reset", 4'b0100);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-sequence reset", 4'b0000);
    in_a = 0; in_b = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 R2 after reset", 4'b0000);

    finish_run();
  end
endmodule